// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block sits next to a shared, word-addressed memory target and enforces load-linked / store-conditional semantics for a fixed number of initiators. Each initiator owns exactly one reservation slot, indexed by its source identifier. A linked read arms the slot with the accessed word address. Any write that is committed to the memory disarms every slot holding that address. A store-conditional is allowed through to memory only when the requester's own slot is still armed on that same address.

Requests arrive one word per cycle on a plain strobe (`req_valid`) with a command, a word address and a source ID. The block is always able to accept a request, so there is no back-pressure and no ready signal. The memory write enable and the store-conditional result are combinational outputs in the same cycle as the request. Slot state changes take effect from the following cycle.

A multi-word request is presented as consecutive words at base plus word index, and each word is judged on its own. The memory array, segment decoding, burst sequencing and response timing belong to neighbouring logic.

Top module: `llsc_resv_table`

## Requirements
- R1: After reset every slot is disarmed, so a store-conditional from any source ID fails (`sc_status` = 1, `mem_wr_en` = 0) until a linked read arms it.
- R2: A linked read (`req_cmd` = 2) from source S at address A arms slot S with A. A later store-conditional (`req_cmd` = 3) from S at A succeeds: in that cycle `mem_wr_en` = 1, `sc_valid` = 1 and `sc_status` = 0.
- R3: A successful store-conditional disarms the reservation it used, so a repeated store-conditional from S at A fails.
- R4: A plain write (`req_cmd` = 1) to address A from any source disarms every slot armed on A, including slots owned by other initiators.
- R5: A write to an address different from a slot's reserved address leaves that slot armed.
- R6: A store-conditional from S at an address other than the one S reserved fails with no write. S keeps its reservation.
- R7: A store-conditional from an initiator without its own reservation fails, even when another initiator holds one on that address. The other reservation stays intact.
- R8: A new linked read from S replaces the address held in slot S, so only the newest address can succeed.
- R9: A plain read (`req_cmd` = 0) changes no reservation.
- R10: Source IDs at or above `NUM_INIT` own no slot. Their linked reads arm nothing and disturb no other slot, and their store-conditionals always fail. Their writes still disarm matching slots.
- R11: `mem_wr_en` is 1 in the request cycle for every valid write and successful store-conditional, and 0 otherwise. `sc_valid` is 1 only for a valid store-conditional, and `sc_status` is 0 when `sc_valid` is 0.
- R12: Consecutive words of a burst at base plus index are judged independently, each against the slot state left by the words before it.
- R13: A successful store-conditional at A also disarms reservations of other initiators on A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, disarms all slots |
| req_valid | input | 1 | Request strobe, one word per cycle, always accepted |
| req_cmd | input | 2 | 0 read, 1 write, 2 linked read, 3 store-conditional |
| req_addr | input | ADDR_W | Word address of this request word |
| req_src | input | SRC_W | Source identifier of the requester |
| mem_wr_en | output | 1 | Write enable to the memory for this word |
| sc_valid | output | 1 | Store-conditional result is present this cycle |
| sc_status | output | STAT_W | Status word returned: 0 success, 1 failure |

## Verification
The interesting coincidence is a committed store-conditional. In one cycle it decides pass for its own slot and disarms every other slot holding the same address. The bench arms two initiators on one address, lets one succeed and judges the clearing through the other initiator's store-conditional, which must then fail. A second overlap is a plain write disarming several slots at once, provoked by arming two slots on one address before a foreign write and checked by both owners' store-conditionals failing.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_LINKED = 2'd2,
    CMD_STCOND = 2'd3
  } cmd_e;
endpackage

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              live_o
);
  logic [ADDR_W-1:0] stored_q;
  logic              live_q;

  assign hit_o  = live_q && (stored_q == addr_i);
  assign live_o = live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      stored_q <= '0;
    end else if (set_i) begin
      live_q   <= 1'b1;
      stored_q <= addr_i;
    end else if (clr_i && hit_o) begin
      live_q   <= 1'b0;
    end
  end

  // R8
  arm_takes_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (live_o && stored_q == $past(addr_i)));

  // R4
  write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit_o && !set_i) |=> !live_o);
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int NUM_INIT = 8,
  parameter int SRC_W    = 4
) (
  input  logic                req_valid,
  input  logic [1:0]          req_cmd,
  input  logic [SRC_W-1:0]    req_src,
  input  logic [NUM_INIT-1:0] hit_vec,
  output logic [NUM_INIT-1:0] set_vec,
  output logic                commit_wr,
  output logic                sc_req,
  output logic                sc_pass
);
  logic [NUM_INIT-1:0] own_sel;
  logic                is_write, is_linked;

  assign is_write  = req_valid && (req_cmd == CMD_WRITE);
  assign is_linked = req_valid && (req_cmd == CMD_LINKED);
  assign sc_req    = req_valid && (req_cmd == CMD_STCOND);

  for (genvar i = 0; i < NUM_INIT; i++) begin : g_sel
    assign own_sel[i] = (req_src == SRC_W'(i));
    assign set_vec[i] = is_linked && own_sel[i];
  end

  assign sc_pass   = sc_req && |(hit_vec & own_sel);
  assign commit_wr = is_write || sc_pass;
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int NUM_INIT = 8,
  parameter int SRC_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int STAT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  output logic              mem_wr_en,
  output logic              sc_valid,
  output logic [STAT_W-1:0] sc_status
);
  localparam logic [SRC_W:0] SLOT_LIMIT = (SRC_W+1)'(NUM_INIT);

  logic [NUM_INIT-1:0] hit_vec, live_vec, set_vec;
  logic                commit_wr, sc_req, sc_pass;

  for (genvar i = 0; i < NUM_INIT; i++) begin : g_slot
    llsc_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (commit_wr),
      .addr_i (req_addr),
      .hit_o  (hit_vec[i]),
      .live_o (live_vec[i])
    );
  end

  llsc_decide #(.NUM_INIT(NUM_INIT), .SRC_W(SRC_W)) u_decide (
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_src   (req_src),
    .hit_vec   (hit_vec),
    .set_vec   (set_vec),
    .commit_wr (commit_wr),
    .sc_req    (sc_req),
    .sc_pass   (sc_pass)
  );

  assign mem_wr_en = commit_wr;
  assign sc_valid  = sc_req;
  assign sc_status = (sc_req && !sc_pass) ? STAT_W'(1) : '0;

  // R10
  foreign_src_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && {1'b0, req_src} >= SLOT_LIMIT) |-> (!mem_wr_en && sc_status == STAT_W'(1)));

  // R9
  read_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == CMD_READ) |=> $stable(live_vec));

  // R11
  no_write_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_cmd == CMD_READ || req_cmd == CMD_LINKED)) |-> !mem_wr_en);

  // R2
  pass_needs_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_status == '0) |-> (mem_wr_en && live_vec != '0));

  // R8
  one_arm_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: tb/llsc_resv_table_bench.sv
`timescale 1ns/1ps
module llsc_resv_table_bench;
  localparam int NUM_INIT = 8;
  localparam int SRC_W    = 4;
  localparam int ADDR_W   = 16;
  localparam int STAT_W   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SRC_W-1:0]  req_src = '0;
  logic              mem_wr_en, sc_valid;
  logic [STAT_W-1:0] sc_status;

  llsc_resv_table #(.NUM_INIT(NUM_INIT), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W))
  u_llsc_resv_table (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_src(req_src), .mem_wr_en(mem_wr_en),
    .sc_valid(sc_valid), .sc_status(sc_status)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic              wr;
    logic              scv;
    logic [STAT_W-1:0] st;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  bit                m_live [NUM_INIT];
  logic [ADDR_W-1:0] m_addr [NUM_INIT];

  task automatic clear_model_addr(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < NUM_INIT; i++)
      if (m_live[i] && m_addr[i] == a) m_live[i] = 0;
  endtask

  task automatic op(input logic [1:0] cmd, input logic [ADDR_W-1:0] a,
                    input int src, input string tag);
    exp_t e;
    bit   pass;
    e.wr = 0; e.scv = 0; e.st = '0; e.tag = tag;
    case (cmd)
      2'd1: begin e.wr = 1; clear_model_addr(a); end
      2'd2: if (src < NUM_INIT) begin m_live[src] = 1; m_addr[src] = a; end
      2'd3: begin
        pass = (src < NUM_INIT) && m_live[src] && m_addr[src] == a;
        e.scv = 1;
        e.st  = pass ? '0 : STAT_W'(1);
        e.wr  = pass;
        if (pass) clear_model_addr(a);
      end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_src = SRC_W'(src);
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_src = '0;
  endtask

  // Monitor: samples 5 ns before each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (req_valid && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (mem_wr_en !== e.wr || sc_valid !== e.scv || sc_status !== e.st) begin
          errors++;
          $display("FAIL %s: actual wr=%0b scv=%0b st=%0d expected wr=%0b scv=%0b st=%0d",
                   e.tag, mem_wr_en, sc_valid, sc_status, e.wr, e.scv, e.st);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_INIT; i++) begin m_live[i] = 0; m_addr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    checks++;
    if (mem_wr_en !== 1'b0 || sc_valid !== 1'b0 || sc_status !== '0) begin
      errors++;
      $display("FAIL R11 idle after reset: actual wr=%0b scv=%0b st=%0d expected 0 0 0",
               mem_wr_en, sc_valid, sc_status);
    end

    for (int s = 0; s < NUM_INIT; s++) op(2'd3, 16'h0010, s, "R1 sc after reset");

    op(2'd2, 16'h0020, 1, "R2 linked read");
    op(2'd3, 16'h0020, 1, "R2 sc pass");
    op(2'd3, 16'h0020, 1, "R3 repeat sc fails");

    op(2'd2, 16'h0030, 2, "R4 arm s2");
    op(2'd2, 16'h0030, 3, "R4 arm s3");
    op(2'd1, 16'h0030, 5, "R4 foreign write");
    op(2'd3, 16'h0030, 2, "R4 s2 disarmed");
    op(2'd3, 16'h0030, 3, "R4 s3 disarmed");

    op(2'd2, 16'h0040, 4, "R5 arm");
    op(2'd1, 16'h0041, 0, "R5 other write");
    idle();
    op(2'd3, 16'h0040, 4, "R5 sc pass");

    op(2'd2, 16'h0050, 5, "R6 arm");
    op(2'd3, 16'h0051, 5, "R6 wrong addr fails");
    op(2'd3, 16'h0050, 5, "R6 kept");

    op(2'd2, 16'h0060, 6, "R7 arm s6");
    op(2'd2, 16'h0060, 7, "R7 arm s7");
    op(2'd3, 16'h0060, 0, "R7 no own slot");
    op(2'd3, 16'h0060, 6, "R7 s6 intact");
    op(2'd3, 16'h0060, 7, "R13 s7 cleared by sc");

    op(2'd2, 16'h0070, 1, "R8 first arm");
    op(2'd2, 16'h0071, 1, "R8 rearm");
    op(2'd3, 16'h0070, 1, "R8 old addr fails");
    op(2'd3, 16'h0071, 1, "R8 new addr passes");

    op(2'd2, 16'h0080, 2, "R9 arm");
    op(2'd0, 16'h0080, 3, "R9 foreign read");
    op(2'd0, 16'h0080, 2, "R9 own read");
    op(2'd3, 16'h0080, 2, "R9 sc pass");

    op(2'd2, 16'h0090, 1, "R10 arm s1");
    op(2'd2, 16'h0091, 9, "R10 linked from s9");
    op(2'd3, 16'h0091, 9, "R10 s9 sc fails");
    op(2'd3, 16'h0090, 8, "R10 s8 sc fails");
    op(2'd3, 16'h0090, 1, "R10 s1 undisturbed");
    op(2'd2, 16'h00A0, 3, "R10 arm s3");
    op(2'd1, 16'h00A0, 12, "R10 write from s12");
    op(2'd3, 16'h00A0, 3, "R10 s3 disarmed");

    op(2'd2, 16'h00B2, 0, "R12 arm");
    for (int w = 0; w < 4; w++) op(2'd3, 16'h00B0 + 16'(w), 0, "R12 sc burst word");
    op(2'd2, 16'h00C2, 4, "R12 arm s4");
    for (int w = 0; w < 4; w++) op(2'd1, 16'h00C0 + 16'(w), 6, "R12 write burst word");
    op(2'd3, 16'h00C2, 4, "R12 s4 disarmed");

    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 scoreboard drain: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule